// File: doc/BRIEF.md
# RGB Plane Colour Writer

This block sits between a host CPU and a graphics memory built from three separate bit planes: red, green and blue. Each plane is 16 KB deep at one bit per pixel, so one byte of a plane is a horizontal run of eight pixels. Bit n of a byte is pixel n of that run. The host programs a small set of I/O registers, then reaches the planes through a memory-style port. The block drives one RAM port per plane. Each plane RAM returns read data one clock after the address.

There are two write paths. In direct mode a host write goes to the one plane picked by the plane-select field, and a host read returns that plane's byte. In colour-writer mode a single host write updates all three planes. For each plane the host byte is ANDed with that plane's eight-pixel mask and then combined with the pixels already stored, using a selectable raster operator. This is a read-modify-write: it reads all three planes in the request cycle and writes all three in the next cycle. During that second cycle the block reports busy.

Top module: `rgb_plane_writer`

## Requirements
- R1: After reset the three masks are 0x00, the plane select is 0 (red), the operator is REPLACE and the block is in colour-writer mode. After reset, busy and read-valid are low and no plane write enable is set.
- R2: I/O writes to 0xAA, 0xAB and 0xAC load the red, green and blue masks. Mask bit n governs pixel bit n of a byte.
- R3: An I/O write to 0xA9 loads the plane select from bits 1:0 (0 red, 1 green, 2 blue, 3 none) and the operator from bits 5:4 (00 REPLACE, 01 OR, 10 AND, 11 XOR). I/O writes to addresses that are not decoded change no register.
- R4: Bit 0 of an I/O write to 0xAD picks the write path: 1 selects direct mode and 0 selects colour-writer mode.
- R5: In direct mode a host write stores its byte, at the clock edge of the request, into the selected plane only.
- R6: In direct mode with plane select 3, a host write changes no plane.
- R7: A host read returns the selected plane's byte, with read-valid high, in the cycle after the request. With plane select 3 the read returns 0xFF.
- R8: A colour-writer write reads all three planes in its request cycle. In the next cycle busy is high and all three planes are written at the request address. Busy is low again one cycle later.
- R9: In colour-writer mode each plane's new byte is old OP (data AND mask). For OR, AND and XOR this is the plain bitwise operation. With REPLACE, masked bits come from the data and unmasked bits keep the old value.
- R10: A host request presented while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O register write strobe |
| io_addr | input | 8 | I/O register address |
| io_wdata | input | 8 | I/O register write data |
| mem_req | input | 1 | Host graphics-window access request |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_addr | input | 14 | Byte address inside a plane |
| mem_wdata | input | 8 | Host write data |
| mem_rdata | output | 8 | Host read data, valid with mem_rvalid |
| mem_rvalid | output | 1 | Read data valid |
| mem_busy | output | 1 | Colour-writer write cycle in progress |
| plane_re | output | 3 | Per-plane read enable (bit 0 red, 1 green, 2 blue) |
| plane_we | output | 3 | Per-plane write enable (same bit order) |
| plane_addr | output | 14 | Shared plane RAM address |
| plane_wdata | output | 24 | Plane write data, red in bits 7:0, green 15:8, blue 23:16 |
| plane_rdata | input | 24 | Plane read data, one cycle after address, same packing |

## Verification
Each result arrives at a fixed cycle. A register write takes effect from the cycle after its edge. A direct write lands at the request edge. Read data and read-valid appear one cycle after the request. Colour-writer busy is high in the cycle after the request, and the planes hold their new bytes after the edge that closes that cycle. The bench drives every input on the falling edge and samples outputs on the falling edge just after the edge where each result is due. It counts one cycle per register, and plane contents are always read back through the host read path. Each colour-writer case is checked for busy in both of its cycles and for the all-plane write enable during the busy cycle.

// File: rtl/rgbw_pkg.sv
package rgbw_pkg;

    // three colour planes: index 0 red, 1 green, 2 blue
    localparam int NPLANES = 3;
    localparam int SEL_W   = 2;

    typedef enum logic [1:0] {
        ROP_REPLACE = 2'b00,
        ROP_OR      = 2'b01,
        ROP_AND     = 2'b10,
        ROP_XOR     = 2'b11
    } rop_e;

    typedef struct packed {
        rop_e             rop;
        logic [SEL_W-1:0] sel;
    } mode_t;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_WRITE = 1'b1
    } seq_e;

    // plane select to one-hot enable; code 3 selects nothing
    function automatic logic [NPLANES-1:0] sel_onehot(input logic [SEL_W-1:0] s);
        logic [NPLANES-1:0] r;
        r = '0;
        for (int p = 0; p < NPLANES; p++) begin
            if (s == SEL_W'(p)) r[p] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/rgbw_regs.sv
module rgbw_regs
    import rgbw_pkg::*;
#(
    parameter int               IO_W      = 8,
    parameter int               BYTE_W    = 8,
    parameter logic [IO_W-1:0]  MODE_PORT = 8'hA9,
    parameter logic [IO_W-1:0]  PAGE_PORT = 8'hAD,
    parameter logic [IO_W-1:0]  MASK_PORT = 8'hAA
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            io_wr,
    input  logic [IO_W-1:0]                 io_addr,
    input  logic [BYTE_W-1:0]               io_wdata,
    output logic [NPLANES-1:0][BYTE_W-1:0]  mask,
    output mode_t                           mode,
    output logic                            direct_en
);

    localparam int ROP_LSB = 4;

    logic  mode_hit, page_hit;
    mode_t mode_q;
    logic  direct_q;

    assign mode_hit = io_wr && (io_addr == MODE_PORT);
    assign page_hit = io_wr && (io_addr == PAGE_PORT);

    for (genvar p = 0; p < NPLANES; p++) begin : g_mask
        localparam logic [IO_W-1:0] PORT_P = MASK_PORT + IO_W'(p);
        logic [BYTE_W-1:0] mask_q;
        always_ff @(posedge clk) begin
            if (rst)                              mask_q <= '0;
            else if (io_wr && io_addr == PORT_P)  mask_q <= io_wdata;
        end
        assign mask[p] = mask_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '{rop: ROP_REPLACE, sel: '0};
            direct_q <= 1'b0;
        end else begin
            if (mode_hit) begin
                mode_q.sel <= io_wdata[SEL_W-1:0];
                mode_q.rop <= rop_e'(io_wdata[ROP_LSB +: 2]);
            end
            if (page_hit) direct_q <= io_wdata[0];
        end
    end

    assign mode      = mode_q;
    assign direct_en = direct_q;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask == '0 && mode_q.sel == '0 && mode_q.rop == ROP_REPLACE && !direct_q));

    // R3
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_hit |=> $stable(mode_q));

    // R4
    page_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !page_hit |=> $stable(direct_q));

endmodule

// File: rtl/rgbw_blend.sv
module rgbw_blend
    import rgbw_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  rop_e              rop,
    input  logic [BYTE_W-1:0] old_px,
    input  logic [BYTE_W-1:0] src_px,   // host data already ANDed with mask
    input  logic [BYTE_W-1:0] mask,
    output logic [BYTE_W-1:0] new_px
);

    always_comb begin
        unique case (rop)
            ROP_REPLACE: new_px = (old_px & ~mask) | src_px;
            ROP_OR:      new_px = old_px | src_px;
            ROP_AND:     new_px = old_px & src_px;
            ROP_XOR:     new_px = old_px ^ src_px;
            default:     new_px = old_px;
        endcase
    end

endmodule

// File: rtl/rgbw_seq.sv
module rgbw_seq
    import rgbw_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int BYTE_W = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            mem_req,
    input  logic                            mem_we,
    input  logic [ADDR_W-1:0]               mem_addr,
    input  logic [BYTE_W-1:0]               mem_wdata,
    output logic [BYTE_W-1:0]               mem_rdata,
    output logic                            mem_rvalid,
    output logic                            busy,
    input  logic                            direct_en,
    input  mode_t                           mode,
    input  logic [NPLANES-1:0][BYTE_W-1:0]  mask,
    output logic [NPLANES-1:0]              plane_re,
    output logic [NPLANES-1:0]              plane_we,
    output logic [ADDR_W-1:0]               plane_addr,
    output logic [NPLANES-1:0][BYTE_W-1:0]  plane_wdata,
    input  logic [NPLANES-1:0][BYTE_W-1:0]  plane_rdata
);

    seq_e                           state_q;
    logic [ADDR_W-1:0]              addr_q;
    logic [NPLANES-1:0][BYTE_W-1:0] src_q;
    logic [NPLANES-1:0][BYTE_W-1:0] msk_q;
    logic [NPLANES-1:0][BYTE_W-1:0] blended;
    rop_e                           rop_q;
    logic [SEL_W-1:0]               rsel_q;
    logic                           rvalid_q;

    logic               accept, cw_go, dw_go, rd_go, in_write;
    logic [NPLANES-1:0] sel_hot;

    assign in_write = (state_q == SEQ_WRITE);
    assign accept   = mem_req && !in_write;
    assign cw_go    = accept && mem_we && !direct_en;
    assign dw_go    = accept && mem_we && direct_en;
    assign rd_go    = accept && !mem_we;
    assign sel_hot  = sel_onehot(mode.sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SEQ_IDLE;
            rvalid_q <= 1'b0;
            rsel_q   <= '0;
            addr_q   <= '0;
            rop_q    <= ROP_REPLACE;
            src_q    <= '0;
            msk_q    <= '0;
        end else begin
            state_q  <= cw_go ? SEQ_WRITE : SEQ_IDLE;
            rvalid_q <= rd_go;
            if (rd_go) rsel_q <= mode.sel;
            if (cw_go) begin
                addr_q <= mem_addr;
                rop_q  <= mode.rop;
                for (int p = 0; p < NPLANES; p++) begin
                    src_q[p] <= mem_wdata & mask[p];
                    msk_q[p] <= mask[p];
                end
            end
        end
    end

    for (genvar p = 0; p < NPLANES; p++) begin : g_plane
        rgbw_blend #(.BYTE_W(BYTE_W)) u_blend (
            .rop    (rop_q),
            .old_px (plane_rdata[p]),
            .src_px (src_q[p]),
            .mask   (msk_q[p]),
            .new_px (blended[p])
        );
        assign plane_wdata[p] = in_write ? blended[p] : mem_wdata;
    end

    assign plane_addr = in_write ? addr_q : mem_addr;
    assign plane_re   = (cw_go ? {NPLANES{1'b1}} : '0) | (rd_go ? sel_hot : '0);
    assign plane_we   = in_write ? {NPLANES{1'b1}} : (dw_go ? sel_hot : '0);
    assign busy       = in_write;
    assign mem_rvalid = rvalid_q;

    always_comb begin
        mem_rdata = '1;
        for (int p = 0; p < NPLANES; p++) begin
            if (rsel_q == SEL_W'(p)) mem_rdata = plane_rdata[p];
        end
    end

    // R8
    busy_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    // R8
    cw_all_planes_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (plane_we == {NPLANES{1'b1}} && plane_addr == $past(mem_addr)));

    // R5
    direct_single_plane_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> ($countones(plane_we) <= 1));

    // R6
    sel_none_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && mode.sel == 2'b11) |-> (plane_we == '0));

    // R7
    rvalid_timing_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rvalid |-> $past(mem_req && !mem_we && !busy));

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!mem_rvalid && !busy));

endmodule

// File: rtl/rgb_plane_writer.sv
module rgb_plane_writer
    import rgbw_pkg::*;
#(
    parameter int               ADDR_W    = 14,
    parameter int               BYTE_W    = 8,
    parameter int               IO_W      = 8,
    parameter logic [IO_W-1:0]  MODE_PORT = 8'hA9,
    parameter logic [IO_W-1:0]  PAGE_PORT = 8'hAD,
    parameter logic [IO_W-1:0]  MASK_PORT = 8'hAA,
    localparam int              FLAT_W    = NPLANES * BYTE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                io_wr,
    input  logic [IO_W-1:0]     io_addr,
    input  logic [BYTE_W-1:0]   io_wdata,
    input  logic                mem_req,
    input  logic                mem_we,
    input  logic [ADDR_W-1:0]   mem_addr,
    input  logic [BYTE_W-1:0]   mem_wdata,
    output logic [BYTE_W-1:0]   mem_rdata,
    output logic                mem_rvalid,
    output logic                mem_busy,
    output logic [NPLANES-1:0]  plane_re,
    output logic [NPLANES-1:0]  plane_we,
    output logic [ADDR_W-1:0]   plane_addr,
    output logic [FLAT_W-1:0]   plane_wdata,
    input  logic [FLAT_W-1:0]   plane_rdata
);

    logic [NPLANES-1:0][BYTE_W-1:0] mask;
    logic [NPLANES-1:0][BYTE_W-1:0] wdata_2d;
    logic [NPLANES-1:0][BYTE_W-1:0] rdata_2d;
    mode_t                          mode;
    logic                           direct_en;

    assign rdata_2d    = plane_rdata;
    assign plane_wdata = wdata_2d;

    rgbw_regs #(
        .IO_W      (IO_W),
        .BYTE_W    (BYTE_W),
        .MODE_PORT (MODE_PORT),
        .PAGE_PORT (PAGE_PORT),
        .MASK_PORT (MASK_PORT)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .io_wr     (io_wr),
        .io_addr   (io_addr),
        .io_wdata  (io_wdata),
        .mask      (mask),
        .mode      (mode),
        .direct_en (direct_en)
    );

    rgbw_seq #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .mem_rvalid  (mem_rvalid),
        .busy        (mem_busy),
        .direct_en   (direct_en),
        .mode        (mode),
        .mask        (mask),
        .plane_re    (plane_re),
        .plane_we    (plane_we),
        .plane_addr  (plane_addr),
        .plane_wdata (wdata_2d),
        .plane_rdata (rdata_2d)
    );

endmodule

// File: tb/rgb_plane_writer_tb.sv
module rgb_plane_writer_tb;

    localparam logic [7:0] P_MODE = 8'hA9;
    localparam logic [7:0] P_PAGE = 8'hAD;
    localparam logic [7:0] P_MASK = 8'hAA;

    // {op, mask r/g/b, old r/g/b, data, expected r/g/b}
    localparam int NVEC = 5;
    localparam logic [81:0] CW_VEC [NVEC] = '{
        {2'b00, 8'hF0, 8'h0F, 8'hFF, 8'hAA, 8'hAA, 8'h00, 8'h3C, 8'h3A, 8'hAC, 8'h3C},
        {2'b01, 8'hFF, 8'h00, 8'h81, 8'h10, 8'h55, 8'h00, 8'h0F, 8'h1F, 8'h55, 8'h01},
        {2'b10, 8'hFF, 8'hF0, 8'h00, 8'hF3, 8'hFF, 8'hFF, 8'h3C, 8'h30, 8'h30, 8'h00},
        {2'b11, 8'h01, 8'hFF, 8'h80, 8'h00, 8'hFF, 8'h80, 8'hFF, 8'h01, 8'h00, 8'h00},
        {2'b00, 8'h00, 8'h00, 8'h00, 8'h12, 8'h34, 8'h56, 8'hFF, 8'h12, 8'h34, 8'h56}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_wr = 1'b0;
    logic [7:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        mem_req = 1'b0;
    logic        mem_we = 1'b0;
    logic [13:0] mem_addr = '0;
    logic [7:0]  mem_wdata = '0;
    logic [7:0]  mem_rdata;
    logic        mem_rvalid;
    logic        mem_busy;
    logic [2:0]  plane_re;
    logic [2:0]  plane_we;
    logic [13:0] plane_addr;
    logic [23:0] plane_wdata;
    logic [23:0] plane_rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rgb_plane_writer u_dut (
        .clk         (clk),
        .rst         (rst),
        .io_wr       (io_wr),
        .io_addr     (io_addr),
        .io_wdata    (io_wdata),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .mem_rvalid  (mem_rvalid),
        .mem_busy    (mem_busy),
        .plane_re    (plane_re),
        .plane_we    (plane_we),
        .plane_addr  (plane_addr),
        .plane_wdata (plane_wdata),
        .plane_rdata (plane_rdata)
    );

    // plane RAM model: low address byte only, one-cycle read latency
    logic [7:0] ram [3][256];
    always @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < 3; p++)
                for (int a = 0; a < 256; a++) ram[p][a] <= 8'h00;
        end else begin
            for (int p = 0; p < 3; p++) begin
                if (plane_we[p]) ram[p][plane_addr[7:0]] <= plane_wdata[p*8 +: 8];
                plane_rdata[p*8 +: 8] <= ram[p][plane_addr[7:0]];
            end
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] op, input logic [1:0] sel);
        io_write(P_MODE, {2'b00, op, 2'b00, sel});
    endtask

    task automatic direct_write(input logic [13:0] a, input logic [7:0] d);
        @(negedge clk);
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = a; mem_wdata = d;
        @(negedge clk);
        mem_req = 1'b0; mem_we = 1'b0;
    endtask

    task automatic host_read(input string req, input logic [13:0] a, output logic [7:0] d);
        @(negedge clk);
        mem_req = 1'b1; mem_we = 1'b0; mem_addr = a;
        @(negedge clk);
        mem_req = 1'b0;
        chk(req, {7'b0, mem_rvalid}, 8'h01);
        d = mem_rdata;
    endtask

    task automatic cw_write(input string req, input logic [13:0] a, input logic [7:0] d);
        @(negedge clk);
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = a; mem_wdata = d;
        @(negedge clk);
        mem_req = 1'b0; mem_we = 1'b0;
        chk({req, " busy high"}, {7'b0, mem_busy}, 8'h01);
        chk({req, " all planes written"}, {5'b0, plane_we}, 8'h07);
        @(negedge clk);
        chk({req, " busy low"}, {7'b0, mem_busy}, 8'h00);
    endtask

    task automatic read_plane(input string req, input logic [1:0] sel,
                              input logic [13:0] a, input logic [7:0] exp);
        logic [7:0] d;
        set_mode(2'b00, sel);
        host_read(req, a, d);
        chk(req, d, exp);
    endtask

    initial begin
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state at the ports
        chk("R1 busy", {7'b0, mem_busy}, 8'h00);
        chk("R1 rvalid", {7'b0, mem_rvalid}, 8'h00);
        chk("R1 plane_we", {5'b0, plane_we}, 8'h00);
        // R1 default colour-writer mode with zero masks: write changes nothing
        cw_write("R1 default mode", 14'h0010, 8'hFF);
        io_write(P_PAGE, 8'h01);
        host_read("R1 default select", 14'h0010, d);
        chk("R1 red unchanged", d, 8'h00);

        // R2 R9 R8 R4: vector table of colour-writer cases
        for (int i = 0; i < NVEC; i++) begin
            logic [81:0]  v;
            logic [13:0]  a;
            v = CW_VEC[i];
            a = 14'h0020 + 14'(i);
            io_write(P_PAGE, 8'h01);                // R4 direct mode
            set_mode(2'b00, 2'd0); direct_write(a, v[55:48]);
            set_mode(2'b00, 2'd1); direct_write(a, v[47:40]);
            set_mode(2'b00, 2'd2); direct_write(a, v[39:32]);
            io_write(P_MASK,        v[79:72]);      // R2 red mask
            io_write(P_MASK + 8'd1, v[71:64]);      // R2 green mask
            io_write(P_MASK + 8'd2, v[63:56]);      // R2 blue mask
            set_mode(v[81:80], 2'd0);               // R3 operator
            io_write(P_PAGE, 8'h00);                // R4 colour-writer mode
            cw_write("R8 colour write", a, v[31:24]);
            io_write(P_PAGE, 8'h01);
            read_plane("R9 red result",   2'd0, a, v[23:16]);
            read_plane("R9 green result", 2'd1, a, v[15:8]);
            read_plane("R9 blue result",  2'd2, a, v[7:0]);
        end

        // R7 plane select 3 reads as all ones
        set_mode(2'b00, 2'd3);
        host_read("R7 sel3 valid", 14'h0030, d);
        chk("R7 sel3 data", d, 8'hFF);

        // R6 direct write with select 3 touches no plane
        direct_write(14'h0030, 8'h5A);
        read_plane("R6 red", 2'd0, 14'h0030, 8'h00);
        read_plane("R6 green", 2'd1, 14'h0030, 8'h00);
        read_plane("R6 blue", 2'd2, 14'h0030, 8'h00);

        // R5 direct write goes to green only
        set_mode(2'b00, 2'd1);
        direct_write(14'h0031, 8'hC3);
        read_plane("R5 red", 2'd0, 14'h0031, 8'h00);
        read_plane("R5 blue", 2'd2, 14'h0031, 8'h00);
        read_plane("R5 green", 2'd1, 14'h0031, 8'hC3);

        // R3 undecoded address leaves select at green
        io_write(8'hA8, 8'h02);
        host_read("R3 ignore valid", 14'h0031, d);
        chk("R3 undecoded write ignored", d, 8'hC3);

        // R7 read data arrives high-address too
        direct_write(14'h3F80, 8'h6E);
        host_read("R7 high addr valid", 14'h3F80, d);
        chk("R7 high addr data", d, 8'h6E);

        // R10 request during busy is ignored
        io_write(P_MASK, 8'hFF);
        set_mode(2'b00, 2'd0);
        io_write(P_PAGE, 8'h00);
        @(negedge clk);
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = 14'h0040; mem_wdata = 8'h11;
        @(negedge clk);
        chk("R10 busy", {7'b0, mem_busy}, 8'h01);
        mem_addr = 14'h0041; mem_wdata = 8'h99;
        @(negedge clk);
        mem_req = 1'b0; mem_we = 1'b0;
        @(negedge clk);
        io_write(P_PAGE, 8'h01);
        read_plane("R10 first write landed", 2'd0, 14'h0040, 8'h11);
        read_plane("R10 second write ignored", 2'd0, 14'h0041, 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule